// File: doc/BRIEF.md
# Temperature Event Alarm Controller

This block holds the configuration register, the three limit registers and the alarm logic of a temperature monitor that sits behind a serial register bus. A bus engine outside the block turns bus transactions into single-cycle register writes and combinational reads. An ADC outside the block supplies a signed two's-complement temperature sample. The block compares that sample with an upper, a lower and a critical limit and drives one event pin.

Software chooses the pin's polarity and whether it is enabled. It also chooses whether only critical crossings raise the pin, and whether the pin follows the live condition (comparator mode) or latches until cleared (interrupt mode). Two sticky lock bits protect the limit registers and the output-shaping fields. Only the power-on reset clears them.

Register map (2-bit address): 0 configuration, 1 upper limit, 2 lower limit, 3 critical limit. Limit registers are DW bits wide, signed. The configuration byte reads back zero-extended to DW bits.

Top module: `temp_alarm_ctrl`

## Requirements
- R1: After power-on reset (rst_n low), every register reads 0 and event_o is high, because the default polarity is active low with the output disabled.
- R2: Configuration bit 7 is the critical lock. A single write of 1 sets it, it reads back 1, and a later write of 0 does not clear it. Only reset clears it.
- R3: While the critical lock is set, writes to the critical limit (address 3) are ignored. Writes to the upper and lower limits are still accepted.
- R4: Configuration bit 6 is the window lock. It is sticky in the same way as bit 7, and while it is set, writes to the upper (address 1) and lower (address 2) limits are ignored.
- R5: Configuration bit 5 always reads 0. Writing 1 to it in interrupt mode clears the latched event. In comparator mode the write leaves event_o unchanged.
- R6: Configuration bit 4 reads 1 exactly when the block is asserting the event. Values written to bit 4 are ignored.
- R7: Configuration bit 3 is the output enable. While it is 0, event_o sits at the inactive level of the selected polarity and bit 4 reads 0.
- R8: Configuration bit 2 selects critical-only events. When it is 1, only a temperature strictly above the critical limit raises the event. When it is 0, an alarm-window crossing also raises it.
- R9: Configuration bit 1 is the polarity: 0 means active low (the active event_o level is 0), 1 means active high.
- R10: While either lock is set, writes do not change bits 3, 2 and 1. Bit 0 stays writable.
- R11: Configuration bit 0 selects the mode. 0 is comparator mode, where event_o follows the condition combinationally. 1 is interrupt mode, where the event latches one clock after the condition and holds until it is cleared.
- R12: The window condition is temperature > upper or temperature < lower. The critical condition is temperature > critical. All three compares are signed and strict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| reg_wr | input | 1 | One-cycle register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the addressed register (combinational) |
| temp_in | input | DW | Signed temperature sample |
| event_o | output | 1 | Event pin, polarity per configuration bit 1 |

## Verification
The bench drives temperatures exactly on each limit and one step past it, and at the most negative and most positive codes. A design with non-strict or unsigned compares fires on an equal value or misses a negative one. It checks that a lock survives a write of 0, which a design that stores the lock as an ordinary bit would clear. It checks that locks freeze the output-shaping fields while leaving the mode bit writable. It also checks that the window lock and the critical lock each protect only their own limits, which a design with one shared lock would get wrong. Finally, it sends the clear bit in both modes: a design that applies it in comparator mode, or ignores it in interrupt mode, shows the wrong event_o level.

// File: rtl/tac_pkg.sv
// Package: shared register selects and configuration layout for the
// temperature event alarm controller.
package tac_pkg;

    // Register selects; the bus engine decodes these same codes.
    typedef enum logic [1:0] {
        SEL_CFG   = 2'd0,
        SEL_UPPER = 2'd1,
        SEL_LOWER = 2'd2,
        SEL_CRIT  = 2'd3
    } reg_sel_e;

    // Configuration bit positions; software relies on them.
    localparam int unsigned B_LOCK_CRIT = 7;
    localparam int unsigned B_LOCK_WIN  = 6;
    localparam int unsigned B_CLEAR     = 5;
    localparam int unsigned B_STATUS    = 4;
    localparam int unsigned B_ENABLE    = 3;
    localparam int unsigned B_CRIT_ONLY = 2;
    localparam int unsigned B_POLARITY  = 1;
    localparam int unsigned B_MODE      = 0;
    localparam int unsigned CFG_W       = 8;

    // Stored configuration state; clear and status are not stored here.
    typedef struct packed {
        logic lock_crit;
        logic lock_win;
        logic enable;
        logic crit_only;
        logic polarity;
        logic mode;
    } cfg_t;

endpackage

// File: rtl/tac_cfg_reg.sv
// Module: configuration register with sticky lock bits.
// Assumes a one-cycle write strobe already qualified for the config address.
// Locks only ever set; rst_n is the power-on reset and the only way to clear them.
module tac_cfg_reg
    import tac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cfg,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg_q,
    output logic             clr_pulse
);

    logic any_lock;
    logic unused_status_wr;

    assign any_lock         = cfg_q.lock_crit | cfg_q.lock_win;
    assign unused_status_wr = wdata[B_STATUS];
    assign clr_pulse        = wr_cfg & wdata[B_CLEAR];

    // Update configuration: locks are sticky, shaping fields obey locks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_cfg) begin
            cfg_q.lock_crit <= cfg_q.lock_crit | wdata[B_LOCK_CRIT];
            cfg_q.lock_win  <= cfg_q.lock_win  | wdata[B_LOCK_WIN];
            cfg_q.mode      <= wdata[B_MODE];
            if (!any_lock) begin
                cfg_q.enable    <= wdata[B_ENABLE];
                cfg_q.crit_only <= wdata[B_CRIT_ONLY];
                cfg_q.polarity  <= wdata[B_POLARITY];
            end
        end
    end

endmodule

// File: rtl/tac_limit_regs.sv
// Module: upper, lower and critical limit registers.
// The critical slot obeys the critical lock; the window slots obey the window lock.
// Assumes lock inputs are the registered lock state (before the current write).
module tac_limit_regs
    import tac_pkg::*;
#(
    parameter int unsigned DW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           sel,
    input  logic [DW-1:0]        wdata,
    input  logic                 lock_crit,
    input  logic                 lock_win,
    output logic signed [DW-1:0] upper_q,
    output logic signed [DW-1:0] lower_q,
    output logic signed [DW-1:0] crit_q
);

    localparam int unsigned NSLOT = 3;

    logic signed [DW-1:0] slot_q [NSLOT];

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        localparam logic [1:0] MY_SEL = 2'(i + 1);
        logic slot_lock;
        assign slot_lock = (MY_SEL == SEL_CRIT) ? lock_crit : lock_win;

        // Hold one limit; accept a write only when its lock is clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else if (wr_en && sel == MY_SEL && !slot_lock)
                slot_q[i] <= wdata;
        end
    end

    assign upper_q = slot_q[0];
    assign lower_q = slot_q[1];
    assign crit_q  = slot_q[2];

endmodule

// File: rtl/tac_event_logic.sv
// Module: limit compare, interrupt latch and pin shaping.
// Compares are signed and strict. Comparator mode is combinational from
// temp_in; interrupt mode latches one clock after the condition.
module tac_event_logic
    import tac_pkg::*;
#(
    parameter int unsigned DW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] temp,
    input  logic signed [DW-1:0] upper,
    input  logic signed [DW-1:0] lower,
    input  logic signed [DW-1:0] crit,
    input  cfg_t                 cfg,
    input  logic                 clr_pulse,
    output logic                 active,
    output logic                 event_o
);

    logic cond_win;
    logic cond_crit;
    logic cond;
    logic latch_q;

    // Evaluate window and critical conditions.
    always_comb begin
        cond_win  = (temp > upper) || (temp < lower);
        cond_crit = (temp > crit);
        cond      = cfg.crit_only ? cond_crit : (cond_win || cond_crit);
    end

    // Interrupt latch: only live in interrupt mode, clear wins over set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= 1'b0;
        else if (!cfg.mode || clr_pulse)
            latch_q <= 1'b0;
        else if (cfg.enable && cond)
            latch_q <= 1'b1;
    end

    // Shape the pin: gate by enable, then apply polarity.
    always_comb begin
        active  = cfg.enable & (cfg.mode ? latch_q : cond);
        event_o = cfg.polarity ? active : ~active;
    end

endmodule

// File: rtl/temp_alarm_ctrl.sv
// Module: top of the temperature event alarm controller.
// Decodes register writes, muxes reads and joins config, limits and event logic.
// Assumes DW >= 8 so the configuration byte fits the data bus.
module temp_alarm_ctrl
    import tac_pkg::*;
#(
    parameter int unsigned DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] temp_in,
    output logic          event_o
);

    cfg_t                 cfg_q;
    logic                 clr_pulse;
    logic                 active;
    logic                 wr_cfg;
    logic signed [DW-1:0] upper_q;
    logic signed [DW-1:0] lower_q;
    logic signed [DW-1:0] crit_q;
    logic [CFG_W-1:0]     cfg_byte;

    assign wr_cfg = reg_wr && (reg_addr == SEL_CFG);

    tac_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cfg    (wr_cfg),
        .wdata     (reg_wdata[CFG_W-1:0]),
        .cfg_q     (cfg_q),
        .clr_pulse (clr_pulse)
    );

    tac_limit_regs #(.DW(DW)) u_lim (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .sel       (reg_addr),
        .wdata     (reg_wdata),
        .lock_crit (cfg_q.lock_crit),
        .lock_win  (cfg_q.lock_win),
        .upper_q   (upper_q),
        .lower_q   (lower_q),
        .crit_q    (crit_q)
    );

    tac_event_logic #(.DW(DW)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp      (temp_in),
        .upper     (upper_q),
        .lower     (lower_q),
        .crit      (crit_q),
        .cfg       (cfg_q),
        .clr_pulse (clr_pulse),
        .active    (active),
        .event_o   (event_o)
    );

    // Assemble the readable configuration byte; clear always reads 0.
    always_comb begin
        cfg_byte              = '0;
        cfg_byte[B_LOCK_CRIT] = cfg_q.lock_crit;
        cfg_byte[B_LOCK_WIN]  = cfg_q.lock_win;
        cfg_byte[B_STATUS]    = active;
        cfg_byte[B_ENABLE]    = cfg_q.enable;
        cfg_byte[B_CRIT_ONLY] = cfg_q.crit_only;
        cfg_byte[B_POLARITY]  = cfg_q.polarity;
        cfg_byte[B_MODE]      = cfg_q.mode;
    end

    // Read mux over the four registers.
    always_comb begin
        unique case (reg_addr)
            SEL_CFG:   reg_rdata = DW'(cfg_byte);
            SEL_UPPER: reg_rdata = upper_q;
            SEL_LOWER: reg_rdata = lower_q;
            default:   reg_rdata = crit_q;
        endcase
    end

endmodule

// File: rtl/tac_checker.sv
// Module: property checker for temp_alarm_ctrl, attached by bind.
// Observes ports and the registered config and limit state.
module tac_checker
    import tac_pkg::*;
#(
    parameter int unsigned DW = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [1:0]           reg_addr,
    input logic [DW-1:0]        reg_wdata,
    input logic [DW-1:0]        reg_rdata,
    input logic                 event_o,
    input cfg_t                 cfg_q,
    input logic                 active,
    input logic signed [DW-1:0] upper_q,
    input logic signed [DW-1:0] lower_q,
    input logic signed [DW-1:0] crit_q
);

    logic cfg_write;
    assign cfg_write = reg_wr && (reg_addr == SEL_CFG);

    a_r2_crit_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock_crit |=> cfg_q.lock_crit);

    a_r4_win_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock_win |=> cfg_q.lock_win);

    a_r3_crit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock_crit |=> $stable(crit_q));

    a_r4_window_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock_win |=> ($stable(upper_q) && $stable(lower_q)));

    a_r10_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.lock_crit || cfg_q.lock_win) |=>
            $stable({cfg_q.enable, cfg_q.crit_only, cfg_q.polarity}));

    a_r7_disabled_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.enable |-> (event_o == !cfg_q.polarity));

    a_r5_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == SEL_CFG) |-> !reg_rdata[B_CLEAR]);

    a_r5_clear_in_interrupt: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_write && reg_wdata[B_CLEAR] && reg_wdata[B_MODE]) |=> !active);

    a_r11_interrupt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode && active && !cfg_write) |=> active);

endmodule

bind temp_alarm_ctrl tac_checker #(.DW(DW)) u_tac_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .event_o   (event_o),
    .cfg_q     (cfg_q),
    .active    (active),
    .upper_q   (upper_q),
    .lower_q   (lower_q),
    .crit_q    (crit_q)
);

// File: tb/test_temp_alarm_ctrl.sv
module test_temp_alarm_ctrl;

    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [DW-1:0] temp_in = '0;
    logic          event_o;

    int checks = 0;
    int errors = 0;

    temp_alarm_ctrl #(.DW(DW)) i_temp_alarm_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .temp_in   (temp_in),
        .event_o   (event_o)
    );

    always #10 clk = ~clk;  // 50 MHz

    // Vectors {temp, crit_only, expected active}; limits upper 50, lower -10, crit 80.
    localparam logic [13:0] VEC [12] = '{
        {12'h000, 1'b0, 1'b0},
        {12'h032, 1'b0, 1'b0},
        {12'h033, 1'b0, 1'b1},
        {12'hFF6, 1'b0, 1'b0},
        {12'hFF5, 1'b0, 1'b1},
        {12'h051, 1'b0, 1'b1},
        {12'h051, 1'b1, 1'b1},
        {12'h03C, 1'b1, 1'b0},
        {12'hFCE, 1'b1, 1'b0},
        {12'h050, 1'b1, 1'b0},
        {12'h800, 1'b0, 1'b1},
        {12'h7FF, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic set_temp(input logic [DW-1:0] t);
        @(negedge clk);
        temp_in = t;
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hang counts as a failed check.
    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        do_reset();

        // R1 reset state
        rd(2'd0, v); chk("R1 cfg", v, 0);
        rd(2'd1, v); chk("R1 upper", v, 0);
        rd(2'd2, v); chk("R1 lower", v, 0);
        rd(2'd3, v); chk("R1 crit", v, 0);
        chk("R1 event idle high", event_o, 1);

        // Load limits
        wr(2'd1, 12'h032);
        wr(2'd2, 12'hFF6);
        wr(2'd3, 12'h050);
        rd(2'd2, v); chk("R12 lower readback", v, 12'hFF6);

        // Vector walk: comparator, active high, enabled (R12, R8, R6)
        foreach (VEC[i]) begin
            wr(2'd0, VEC[i][1] ? 12'h00E : 12'h00A);
            set_temp(VEC[i][13:2]);
            chk($sformatf("R12/R8 vec%0d event", i), event_o, VEC[i][0]);
            reg_addr = 2'd0;
            #1 chk($sformatf("R6 vec%0d status", i), reg_rdata[4], VEC[i][0]);
        end

        // R9 polarity active low
        wr(2'd0, 12'h008);
        set_temp(12'h033); chk("R9 active low asserted", event_o, 0);
        set_temp(12'h000); chk("R9 active low idle", event_o, 1);

        // R7 disabled output
        wr(2'd0, 12'h002);
        set_temp(12'h033); chk("R7 disabled pol1 inactive", event_o, 0);
        rd(2'd0, v);       chk("R7 disabled status", v[4], 0);
        wr(2'd0, 12'h000); #1 chk("R7 disabled pol0 inactive", event_o, 1);

        // R6 status write ignored
        set_temp(12'h000);
        wr(2'd0, 12'h01A);
        rd(2'd0, v); chk("R6 status not writable", v, 12'h00A);

        // R11 interrupt latch
        wr(2'd0, 12'h00B);
        #1 chk("R11 interrupt idle", event_o, 0);
        set_temp(12'h033);
        @(negedge clk); #1 chk("R11 latched", event_o, 1);
        set_temp(12'h000);
        @(negedge clk); #1 chk("R11 holds after condition ends", event_o, 1);
        wr(2'd0, 12'h02B);
        #1 chk("R5 clear in interrupt", event_o, 0);
        rd(2'd0, v); chk("R5 clear reads 0", v, 12'h00B);

        // R5 clear has no effect in comparator mode
        wr(2'd0, 12'h00A);
        set_temp(12'h033); chk("R11 comparator follows", event_o, 1);
        wr(2'd0, 12'h02A);
        #1 chk("R5 clear ignored in comparator", event_o, 1);
        rd(2'd0, v); chk("R5 cfg after comparator clear", v, 12'h01A);

        // R4 window lock
        set_temp(12'h000);
        wr(2'd0, 12'h04A);
        rd(2'd0, v); chk("R4 window lock reads 1", v, 12'h04A);
        wr(2'd1, 12'h064);
        rd(2'd1, v); chk("R4 upper frozen", v, 12'h032);
        wr(2'd2, 12'h000);
        rd(2'd2, v); chk("R4 lower frozen", v, 12'hFF6);
        wr(2'd3, 12'h05A);
        rd(2'd3, v); chk("R3 crit writable under window lock", v, 12'h05A);

        // R10 shaping frozen, mode free
        wr(2'd0, 12'h000);
        rd(2'd0, v); chk("R10 fields frozen, lock sticky", v, 12'h04A);
        wr(2'd0, 12'h001);
        rd(2'd0, v); chk("R10 mode still writable", v, 12'h04B);

        // R2 / R3 critical lock
        wr(2'd0, 12'h080);
        rd(2'd0, v); chk("R2 crit lock set by one write", v, 12'h0CA);
        wr(2'd3, 12'h014);
        rd(2'd3, v); chk("R3 crit frozen", v, 12'h05A);
        wr(2'd0, 12'h000);
        rd(2'd0, v); chk("R2 lock survives write of 0", v, 12'h0CA);

        // R1 power-on reset clears locks
        do_reset();
        rd(2'd0, v); chk("R1 reset clears locks", v, 0);
        #1 chk("R1 event after reset", event_o, 1);

        // Critical lock alone: window limits stay writable
        wr(2'd0, 12'h080);
        wr(2'd1, 12'h021);
        rd(2'd1, v); chk("R3 upper writable under crit lock", v, 12'h021);
        wr(2'd3, 12'h005);
        rd(2'd3, v); chk("R3 crit frozen after single lock", v, 0);
        wr(2'd0, 12'h002);
        rd(2'd0, v); chk("R10 polarity frozen by crit lock", v, 12'h080);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule